// File: doc/BRIEF.md
# Accumulator Convergent Rounding Unit

This block turns a wide accumulator value into a word-sized stored operand. Each accepted input produces two results. One is a full-width accumulator whose low part has been either truncated or rounded. The other is the word taken from the middle of that accumulator. The two results are registered and appear together one clock after the input is accepted.

In round mode the block rounds to nearest and breaks an exact tie toward an even kept value. This is convergent rounding, and it avoids the upward bias of half-up rounding when many values are accumulated. A two-bit scaling mode moves the rounding point one bit up or one bit down from its nominal place. A multiply-accumulate-and-round operation feeds its new sum through the same path, so the rounding is applied after the addition. In truncate mode the low part is simply discarded.

Top module: `cr_acc_rounder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `acc_out` and `word_out` all become zero on that edge.
- R2: When `in_valid` is high at an edge, `out_valid` is high on the following cycle and the results for that input appear on the same cycle. When `in_valid` is low at an edge, `out_valid` is low on the following cycle.
- R3: When `in_valid` is low, `acc_out` and `word_out` keep their values, whatever happens on `acc_in`, `round_en` and `scale_mode`.
- R4: With `round_en`=0 the block truncates: `acc_out` equals `acc_in` with bits 23..0 cleared, `word_out` equals `acc_in[47:24]`, and `scale_mode` has no effect.
- R5: With `round_en`=1 and `scale_mode`=2'b00 (no scaling), the block adds 2^23 to the accumulator and then clears bits 23..0.
- R6: With `round_en`=1 and `scale_mode`=2'b01 (scale down), the block adds 2^24 and then clears bits 24..0.
- R7: With `round_en`=1 and `scale_mode`=2'b10 (scale up), the block adds 2^22 and then clears bits 22..0.
- R8: A tie occurs when, in round mode, the bit at the half point (23, 24 or 22, depending on the mode) is 1 and every bit below it is 0. On a tie, the bit just above the half point is also cleared after the addition, which makes the kept value even.
- R9: The reserved scaling code 2'b11 gives the same result as 2'b00.
- R10: A carry out of the rounding addition propagates into the extension bits 55..48. The sum wraps modulo 2^56.
- R11: In round mode, `word_out` equals bits 47..24 of the rounded `acc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept `acc_in` and the mode inputs on this edge |
| acc_in | input | 56 | Accumulator value: extension 55..48, upper part 47..24, lower part 23..0 |
| round_en | input | 1 | 1 = convergent rounding, 0 = truncate |
| scale_mode | input | 2 | 00 none, 01 scale down, 10 scale up, 11 reserved (treated as 00) |
| out_valid | output | 1 | Results on `acc_out`/`word_out` belong to the input accepted one cycle earlier |
| acc_out | output | 56 | Rounded or truncated accumulator |
| word_out | output | 24 | Stored operand, bits 47..24 of `acc_out` |

## Verification
Every result comes from a single output register, so `out_valid`, `acc_out` and `word_out` are due exactly one rising edge after the edge that accepts `in_valid`. The bench drives inputs on a falling edge. It samples on the next falling edge, which is half a period after the capturing edge and before any later input could arrive. For the hold checks, the bench changes the inputs with `in_valid` low and waits two more edges before it samples again. For the reset checks, it samples on the falling edge after the edge at which `rst_n` was seen low.

// File: rtl/cr_pkg.sv
// Package: shared types for the accumulator rounding unit.
// Assumes nothing beyond a two-bit scaling field.
package cr_pkg;

    // Scaling mode field; the reserved code falls back to no scaling.
    typedef enum logic [1:0] {
        SCL_NONE = 2'b00,
        SCL_DOWN = 2'b01,
        SCL_UP   = 2'b10,
        SCL_RSVD = 2'b11
    } scale_mode_e;

endpackage

// File: rtl/cr_pos_decode.sv
// Module: cr_pos_decode
// Turns the scaling mode into three bit masks over the accumulator:
//   half_mask - one-hot at the half point (the bit to which one is added)
//   low_mask  - every bit below the half point
//   keep_mask - one-hot at the lowest kept bit (the bit cleared on a tie)
// Assumes LSB_POS >= 2 and LSB_POS + 2 < ACC_W.
module cr_pos_decode
    import cr_pkg::*;
#(
    parameter int ACC_W   = 56,
    parameter int LSB_POS = 24
) (
    input  scale_mode_e       mode,
    output logic [ACC_W-1:0]  half_mask,
    output logic [ACC_W-1:0]  low_mask,
    output logic [ACC_W-1:0]  keep_mask
);
    localparam int IDX_W = $clog2(ACC_W) + 1;

    logic [IDX_W-1:0] half_idx;
    logic [IDX_W-1:0] keep_idx;

    // Pick the half-point bit index from the scaling mode.
    always_comb begin
        case (mode)
            SCL_DOWN: half_idx = IDX_W'(LSB_POS);
            SCL_UP:   half_idx = IDX_W'(LSB_POS - 2);
            default:  half_idx = IDX_W'(LSB_POS - 1);
        endcase
        keep_idx = half_idx + IDX_W'(1);
    end

    // Expand the indices into per-bit masks.
    for (genvar i = 0; i < ACC_W; i++) begin : g_mask
        assign half_mask[i] = (IDX_W'(i) == half_idx);
        assign low_mask[i]  = (IDX_W'(i) <  half_idx);
        assign keep_mask[i] = (IDX_W'(i) == keep_idx);
    end

endmodule

// File: rtl/cr_round_core.sv
// Module: cr_round_core
// Combinational rounding of one accumulator value.
// Round mode: add the half-point weight, clear the half point and every bit
// below it, and on an exact tie also clear the lowest kept bit (ties to even).
// Truncate mode: clear the lower LSB_POS bits and leave the rest unchanged.
// Assumes the masks come from cr_pos_decode. The sum wraps at ACC_W bits.
module cr_round_core #(
    parameter int ACC_W   = 56,
    parameter int LSB_POS = 24
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             round_en,
    input  logic [ACC_W-1:0] half_mask,
    input  logic [ACC_W-1:0] low_mask,
    input  logic [ACC_W-1:0] keep_mask,
    output logic [ACC_W-1:0] result
);
    localparam logic [ACC_W-1:0] LSP_MASK =
        {{(ACC_W-LSB_POS){1'b0}}, {LSB_POS{1'b1}}};

    logic             is_tie;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] clr_mask;

    // Detect an exact half below the kept bits.
    always_comb is_tie = ((acc & half_mask) != '0) && ((acc & low_mask) == '0);

    // Add the half weight and build the bits to clear.
    always_comb begin
        sum      = acc + half_mask;
        clr_mask = half_mask | low_mask | (is_tie ? keep_mask : '0);
    end

    // Choose between the rounded and the truncated value.
    always_comb result = round_en ? (sum & ~clr_mask) : (acc & ~LSP_MASK);

endmodule

// File: rtl/cr_acc_rounder.sv
// Module: cr_acc_rounder (top)
// Registers the rounded or truncated accumulator and the word taken from it.
// Both appear one cycle after in_valid. They hold while no input is accepted.
// Reset is synchronous and active low. Assumes LSB_POS + WORD_W <= ACC_W.
module cr_acc_rounder
    import cr_pkg::*;
#(
    parameter int ACC_W   = 56,
    parameter int WORD_W  = 24,
    parameter int LSB_POS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic              round_en,
    input  logic [1:0]        scale_mode,
    output logic              out_valid,
    output logic [ACC_W-1:0]  acc_out,
    output logic [WORD_W-1:0] word_out
);
    localparam int WORD_HI = LSB_POS + WORD_W - 1;

    logic [ACC_W-1:0] half_mask;
    logic [ACC_W-1:0] low_mask;
    logic [ACC_W-1:0] keep_mask;
    logic [ACC_W-1:0] rnd_acc;

    cr_pos_decode #(.ACC_W(ACC_W), .LSB_POS(LSB_POS)) u_pos (
        .mode      (scale_mode_e'(scale_mode)),
        .half_mask (half_mask),
        .low_mask  (low_mask),
        .keep_mask (keep_mask)
    );

    cr_round_core #(.ACC_W(ACC_W), .LSB_POS(LSB_POS)) u_core (
        .acc       (acc_in),
        .round_en  (round_en),
        .half_mask (half_mask),
        .low_mask  (low_mask),
        .keep_mask (keep_mask),
        .result    (rnd_acc)
    );

    // Capture results on accepted inputs; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            word_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out  <= rnd_acc;
                word_out <= rnd_acc[WORD_HI:LSB_POS];
            end
        end
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc_out) && $stable(word_out)));

    // R4
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !round_en) |=>
            ((acc_out >> LSB_POS) == ($past(acc_in) >> LSB_POS)) &&
            (acc_out[LSB_POS-1:0] == '0));

    // R5
    nominal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && round_en && (scale_mode != 2'b01)) |=>
            (acc_out[LSB_POS-2:0] == '0));

    // R8
    tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && round_en && (scale_mode == 2'b00) &&
         (acc_in[LSB_POS-1:0] == {1'b1, {(LSB_POS-1){1'b0}}})) |=>
            !acc_out[LSB_POS]);

endmodule

// File: tb/cr_acc_rounder_tb.sv
`timescale 1ns/1ps
module cr_acc_rounder_tb;
    localparam int ACC_W  = 56;
    localparam int WORD_W = 24;
    localparam int NVEC   = 20;

    typedef struct packed {
        logic             rnd;
        logic [1:0]       mode;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] exp;
        logic [3:0]       req;
    } vec_t;

    // Vectors: round_en, scale_mode, acc_in, expected acc_out, requirement.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b00, 56'h00123456ABCDEF, 56'h00123456000000, 4'd4},  // R4
        '{1'b0, 2'b01, 56'hFF800000FFFFFF, 56'hFF800000000000, 4'd4},  // R4
        '{1'b0, 2'b10, 56'h00123456800000, 56'h00123456000000, 4'd4},  // R4
        '{1'b1, 2'b00, 56'h001234567FFFFF, 56'h00123456000000, 4'd5},  // R5
        '{1'b1, 2'b00, 56'h00123456800001, 56'h00123457000000, 4'd5},  // R5
        '{1'b1, 2'b00, 56'h00123456800000, 56'h00123456000000, 4'd8},  // R8
        '{1'b1, 2'b00, 56'h00123457800000, 56'h00123458000000, 4'd8},  // R8
        '{1'b1, 2'b01, 56'h00123455000001, 56'h00123456000000, 4'd6},  // R6
        '{1'b1, 2'b01, 56'h00123455000000, 56'h00123454000000, 4'd8},  // R8
        '{1'b1, 2'b01, 56'h00123457000000, 56'h00123458000000, 4'd8},  // R8
        '{1'b1, 2'b10, 56'h001234563FFFFF, 56'h00123456000000, 4'd7},  // R7
        '{1'b1, 2'b10, 56'h00123456400001, 56'h00123456800000, 4'd7},  // R7
        '{1'b1, 2'b10, 56'h00123456C00000, 56'h00123457000000, 4'd8},  // R8
        '{1'b1, 2'b10, 56'h00123456400000, 56'h00123456000000, 4'd8},  // R8
        '{1'b1, 2'b11, 56'h00123456800001, 56'h00123457000000, 4'd9},  // R9
        '{1'b1, 2'b11, 56'h00123456800000, 56'h00123456000000, 4'd9},  // R9
        '{1'b1, 2'b00, 56'h00FFFFFF900000, 56'h01000000000000, 4'd10}, // R10
        '{1'b1, 2'b00, 56'hFFFFFFFFC00000, 56'h00000000000000, 4'd10}, // R10
        '{1'b1, 2'b00, 56'hFFFFFFFF800000, 56'h00000000000000, 4'd8},  // R8
        '{1'b1, 2'b00, 56'hFF800000400000, 56'hFF800000000000, 4'd5}   // R5
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ACC_W-1:0]  acc_in = '0;
    logic              round_en = 1'b0;
    logic [1:0]        scale_mode = 2'b00;
    logic              out_valid;
    logic [ACC_W-1:0]  acc_out;
    logic [WORD_W-1:0] word_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cr_acc_rounder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .acc_in     (acc_in),
        .round_en   (round_en),
        .scale_mode (scale_mode),
        .out_valid  (out_valid),
        .acc_out    (acc_out),
        .word_out   (word_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic r, input logic [1:0] m, input logic [ACC_W-1:0] a);
        @(negedge clk);
        in_valid   = 1'b1;
        round_en   = r;
        scale_mode = m;
        acc_in     = a;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 acc_out", 64'(acc_out), 64'd0);
        check("R1 word_out", 64'(word_out), 64'd0);
        rst_n = 1'b1;

        // Table walk: each result is sampled one edge after it is accepted.
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            apply(VECS[i].rnd, VECS[i].mode, VECS[i].acc);
            @(negedge clk);
            in_valid = 1'b0;
            check({tag, " out_valid R2"}, 64'(out_valid), 64'd1);
            check({tag, " acc_out"}, 64'(acc_out), 64'(VECS[i].exp));
            check({tag, " word_out R11"}, 64'(word_out), 64'(VECS[i].exp[47:24]));
        end

        // R2: idle cycle drops out_valid
        @(negedge clk);
        check("R2 idle out_valid", 64'(out_valid), 64'd0);

        // R2: back-to-back inputs, each due one cycle later
        apply(1'b1, 2'b00, 56'h00000001800000);
        apply(1'b1, 2'b01, 56'h00000003000000);
        check("R2 b2b first", 64'(acc_out), 64'h00000002000000);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second", 64'(acc_out), 64'h00000004000000);
        check("R2 b2b valid", 64'(out_valid), 64'd1);

        // R3: inputs change without in_valid; outputs hold
        acc_in     = 56'h00ABCDEF123456;
        round_en   = 1'b0;
        scale_mode = 2'b10;
        repeat (2) @(negedge clk);
        check("R3 hold acc_out", 64'(acc_out), 64'h00000004000000);
        check("R3 hold word_out", 64'(word_out), 64'h000004);

        // R1: reset in mid-run wins over a valid input
        apply(1'b1, 2'b00, 56'h00FFFFFFFFFFFF);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 mid reset valid", 64'(out_valid), 64'd0);
        check("R1 mid reset acc", 64'(acc_out), 64'd0);
        check("R1 mid reset word", 64'(word_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule